// File: doc/BRIEF.md
# Ethernet PHY Management Bus Master

This block is the management-side master for the two-wire serial bus used to reach the registers of an Ethernet PHY. A host hands it one request at a time: a read or a write, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block turns that request into a complete serial frame. It produces the management clock and drives the shared data line through separate output, output-enable and input pins, so that the pad ring can build the bidirectional buffer.

Every frame opens with a run of 32 clock pulses with the data line held high. The header follows, sent most-significant bit first. On a write, the master keeps driving the line for a two-bit turnaround and then sends the data. On a read, the master releases the line while the clock is low and gives one turnaround pulse. It then samples the line once. A high value there means no PHY answered, and the read returns zero with an error flag. After one more pulse, sixteen data bits are shifted in. At the end of a frame the master takes the line back while the clock is low, and pulses done.

The management clock rate comes from a parameter: each clock phase lasts HALF_DIV system clocks. With the default and a 50 MHz system clock, the bus runs at 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset and while no request is pending, busy, done and mdc are low and mdio_oe is high.
- R2: Each frame begins with 32 mdc pulses during which mdio_o is driven high.
- R3: After the preamble, the master drives a 14-bit header, MSB first, one bit per mdc pulse: start code 01, then opcode (10 for a read, 01 for a write), then the PHY address, then the register address.
- R4: On a write, the header is followed by the driven turnaround pattern 10 and then the 16 write-data bits, MSB first. A write is 64 driven pulses in total.
- R5: mdio_o changes only while mdc is low and never in the same cycle as a rising mdc edge. A slave that samples on the rising edge therefore sees stable data.
- R6: mdio_oe changes only while mdc is low, and never in the same cycle as an mdc edge.
- R7: On a read, mdio_oe is already low at the turnaround pulse (rising edge 47). The read has 18 pulses with the line released, for a total of 64 pulses.
- R8: On a read, the bit present on mdio_i before rising edge n (n = 49 to 64) becomes read-data bit 64-n. rd_data is valid during the done pulse.
- R9: If mdio_i is high before rising edge 48 (the sample after the turnaround pulse), the read ends with rd_error high and rd_data zero. A write always ends with rd_error low.
- R10: Every mdc high phase lasts exactly HALF_DIV system clock cycles.
- R11: busy is high from the cycle after a request is accepted until done pulses. done is high for one cycle per frame. A request presented while busy is high is ignored.
- R12: In the done cycle, mdc is low and mdio_oe is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Read result, valid during done |
| rd_error | output | 1 | Read found no responding PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The embedded assertions check the following on every cycle of every run:
- the data and direction pins change only in the low phase of mdc;
- the clock moves only on a divider tick;
- the preamble bits are high;
- done never lasts two cycles;
- a failed read returns zero.

Only the bench scenarios can show the things that depend on a whole frame. These are:
- the bit order of the header and the write payload;
- the pulse counts with the line driven and with it released;
- the mapping of sampled bits to read-data positions;
- a request made during a frame being ignored.

The bench sweeps all 32 PHY addresses with both reads and writes, and includes reads where no PHY answers.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int PRE_LEN = 32;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] WR_TURN    = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_REL,
        ST_RX,
        ST_FIN
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
    import mdio_pkg::*;
#(
    parameter int PW   = PHY_W,
    parameter int RW   = REG_W,
    parameter int DW   = DATA_W,
    parameter int PRE  = PRE_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [PW-1:0] req_phy_i,
    input  logic [RW-1:0] req_reg_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          mdio_i,
    output logic          mdc_o,
    output logic          mdio_o,
    output logic          mdio_oe_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_err_o
);
    localparam int HDR_BITS = 4 + PW + RW;
    localparam int RD_DRV   = PRE + HDR_BITS;
    localparam int WR_BITS  = RD_DRV + 2 + DW;
    localparam int RX_SLOTS = 2 + DW;
    localparam int CW       = $clog2(WR_BITS + 1);

    typedef struct packed {
        mdio_state_e       st;
        logic              mdc;
        logic              oe;
        logic              mdo;
        logic [WR_BITS-1:0] tx;
        logic [CW-1:0]     cnt;
        logic [DW-1:0]     rx;
        logic              err;
        logic              is_rd;
        logic              done;
        logic              rd_err;
        logic [DW-1:0]     rd;
    } seq_t;

    localparam seq_t RST_VAL = '{st: ST_IDLE, mdc: 1'b0, oe: 1'b1, mdo: 1'b1,
                                 tx: '0, cnt: '0, rx: '0, err: 1'b0,
                                 is_rd: 1'b0, done: 1'b0, rd_err: 1'b0,
                                 rd: '0};

    seq_t seq_d, seq_q;
    logic [HDR_BITS-1:0] hdr;

    always_comb begin
        hdr = {START_CODE, (req_write_i ? OP_WRITE : OP_READ),
               req_phy_i, req_reg_i};
        seq_d = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    seq_d.is_rd = !req_write_i;
                    if (req_write_i) begin
                        seq_d.tx  = {{PRE{1'b1}}, hdr, WR_TURN, req_wdata_i};
                        seq_d.cnt = CW'(WR_BITS);
                    end else begin
                        seq_d.tx  = {{PRE{1'b1}}, hdr,
                                     {(WR_BITS - RD_DRV){1'b0}}};
                        seq_d.cnt = CW'(RD_DRV);
                    end
                    seq_d.mdc = 1'b0;
                    seq_d.oe  = 1'b1;
                    seq_d.mdo = 1'b1;
                    seq_d.err = 1'b0;
                    seq_d.rx  = '0;
                    seq_d.st  = ST_TX;
                end
            end
            ST_TX: begin
                if (tick_i) begin
                    if (!seq_q.mdc) begin
                        seq_d.mdc = 1'b1;
                    end else begin
                        seq_d.mdc = 1'b0;
                        seq_d.tx  = seq_q.tx << 1;
                        seq_d.mdo = seq_q.tx[WR_BITS-2];
                        seq_d.cnt = seq_q.cnt - CW'(1);
                        if (seq_q.cnt == CW'(1))
                            seq_d.st = seq_q.is_rd ? ST_REL : ST_FIN;
                    end
                end
            end
            ST_REL: begin
                if (tick_i) begin
                    seq_d.oe  = 1'b0;
                    seq_d.cnt = CW'(RX_SLOTS);
                    seq_d.st  = ST_RX;
                end
            end
            ST_RX: begin
                if (tick_i) begin
                    if (!seq_q.mdc) begin
                        seq_d.mdc = 1'b1;
                        if (seq_q.cnt == CW'(RX_SLOTS - 1))
                            seq_d.err = mdio_i;
                        if (seq_q.cnt <= CW'(DW))
                            seq_d.rx = {seq_q.rx[DW-2:0], mdio_i};
                    end else begin
                        seq_d.mdc = 1'b0;
                        seq_d.cnt = seq_q.cnt - CW'(1);
                        if (seq_q.cnt == CW'(1)) seq_d.st = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                if (tick_i) begin
                    seq_d.oe     = 1'b1;
                    seq_d.mdo    = 1'b1;
                    seq_d.done   = 1'b1;
                    seq_d.rd_err = seq_q.is_rd && seq_q.err;
                    seq_d.rd     = (seq_q.is_rd && !seq_q.err) ? seq_q.rx : '0;
                    seq_d.st     = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= RST_VAL;
        else        seq_q <= seq_d;
    end

    assign mdc_o     = seq_q.mdc;
    assign mdio_o    = seq_q.mdo;
    assign mdio_oe_o = seq_q.oe;
    assign busy_o    = (seq_q.st != ST_IDLE);
    assign done_o    = seq_q.done;
    assign rd_data_o = seq_q.rd;
    assign rd_err_o  = seq_q.rd_err;

    // R5
    mdo_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.mdc |-> $stable(seq_q.mdo));

    // R6
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q.oe) |-> (!seq_q.mdc && !$past(seq_q.mdc)));

    // R10
    mdc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q.mdc) |-> $past(tick_i));

    // R2
    preamble_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TX && seq_q.cnt >
            (seq_q.is_rd ? CW'(RD_DRV - PRE) : CW'(WR_BITS - PRE)))
        |-> seq_q.mdo);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.done && seq_q.rd_err) |-> (seq_q.rd == '0));

    // R12
    fin_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (seq_q.oe && !seq_q.mdc));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_error,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic tick;

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .tick_o (tick)
    );

    mdio_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_phy_i   (req_phy),
        .req_reg_i   (req_reg),
        .req_wdata_i (req_wdata),
        .mdio_i      (mdio_i),
        .mdc_o       (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe_o   (mdio_oe),
        .busy_o      (busy),
        .done_o      (done),
        .rd_data_o   (rd_data),
        .rd_err_o    (rd_error)
    );
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rd_error, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    // monitor state
    int          rises = 0, drv = 0, nodrv = 0, hi_len = 0, hi_bad = 0, dones = 0;
    logic [63:0] cap = '0;
    logic        ta_oe = 1'b1;
    logic        mdc_prev = 1'b0;
    logic [15:0] resp_data = '0;
    logic        resp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_error(rd_error),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: error bit before rise 48, data MSB first before rises 49..64
    always_comb begin
        if (rises == 47)                    mdio_i = resp_err;
        else if (rises >= 48 && rises <= 63) mdio_i = resp_data[63 - rises];
        else                                mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            rises = rises + 1;
            if (mdio_oe) begin
                cap = {cap[62:0], mdio_o};
                drv = drv + 1;
            end else begin
                nodrv = nodrv + 1;
            end
            if (rises == 47) ta_oe = mdio_oe;
        end
        if (mdc) hi_len = hi_len + 1;
        if (!mdc && mdc_prev) begin
            if (hi_len != HALF) hi_bad = hi_bad + 1;
            hi_len = 0;
        end
        if (done) dones = dones + 1;
        mdc_prev = mdc;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] prd,
                           input bit perr, input bit stray);
        logic [13:0] hdr;
        logic [15:0] exp_rd;
        bit got;
        hdr = {2'b01, (wr ? 2'b01 : 2'b10), phy, ra};
        exp_rd = (!wr && !perr) ? prd : 16'h0;
        @(posedge clk); #1;
        resp_data = prd; resp_err = perr;
        rises = 0; drv = 0; nodrv = 0; hi_bad = 0; dones = 0; cap = '0; ta_oe = 1'b1;
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
        got = 0;
        for (int k = 0; k < 2000; k++) begin
            if (stray && k == 40) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy;
                req_reg = ~ra; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk); #1;
            if (done) begin got = 1; break; end
        end
        req_valid = 1'b0;
        chk(got, "R11 done seen", 64'(got), 64'd1);
        chk(!mdc && mdio_oe, "R12 line owned at done", {62'd0, mdc, mdio_oe}, 64'd1);
        chk(rd_data == exp_rd, "R8 R9 read data", 64'(rd_data), 64'(exp_rd));
        chk(rd_error == (!wr && perr), "R9 error flag", 64'(rd_error), 64'(!wr && perr));
        @(posedge clk); #1;
        chk(!done && !busy, "R11 done one cycle then idle", {62'd0, done, busy}, 64'd0);
        @(negedge clk); #1;
        chk(dones == 1, "R11 single done, stray ignored", 64'(dones), 64'd1);
        chk(rises == 64, "R2 R4 R7 pulse count", 64'(rises), 64'd64);
        chk(hi_bad == 0, "R10 high phase length", 64'(hi_bad), 64'd0);
        if (wr) begin
            chk(drv == 64, "R4 driven pulses", 64'(drv), 64'd64);
            chk(cap[63:32] == 32'hFFFF_FFFF, "R2 preamble", 64'(cap[63:32]), 64'hFFFF_FFFF);
            chk(cap[31:18] == hdr, "R3 header", 64'(cap[31:18]), 64'(hdr));
            chk(cap[17:0] == {2'b10, wd}, "R4 turnaround and data",
                64'(cap[17:0]), 64'({2'b10, wd}));
        end else begin
            chk(drv == 46 && nodrv == 18, "R7 driven/released pulses",
                64'(drv * 256 + nodrv), 64'(46 * 256 + 18));
            chk(ta_oe == 1'b0, "R7 released at turnaround", 64'(ta_oe), 64'd0);
            chk(cap[45:14] == 32'hFFFF_FFFF, "R2 preamble", 64'(cap[45:14]), 64'hFFFF_FFFF);
            chk(cap[13:0] == hdr, "R3 header", 64'(cap[13:0]), 64'(hdr));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !mdc && mdio_oe, "R1 reset state",
            {60'd0, busy, done, mdc, mdio_oe}, 64'd1);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk(!busy && !done && !mdc && mdio_oe, "R1 idle after reset",
            {60'd0, busy, done, mdc, mdio_oe}, 64'd1);
        for (int p = 0; p < 32; p++) begin
            logic [4:0]  ra;
            logic [15:0] wd;
            ra = 5'((p * 7) % 32);
            wd = 16'(p * 16'h0841) ^ 16'hA5C3;
            run_txn(1'b1, 5'(p), ra, wd, 16'h0, 1'b0, p == 4);
            run_txn(1'b0, 5'(p), ~ra, 16'h0, ~wd ^ 16'(p), (p % 5) == 3, p == 9);
        end
        run_txn(1'b0, 5'h1F, 5'h1F, 16'h0, 16'hFFFF, 1'b0, 1'b0);
        run_txn(1'b0, 5'h00, 5'h00, 16'h0, 16'h8001, 1'b0, 1'b0);
        run_txn(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule